// File: doc/BRIEF.md
# Display Identification I2C Target

This block answers on a display data channel as the monitor side of the link. It holds a fixed 128-byte identification table. The controller reads this table over I2C to learn what kind of display is attached. The table is constant from reset, with one exception: the last byte is a checksum. The block works that byte out itself in the first cycles after reset, adding one table byte per clock.

The block answers one 7-bit bus address. A write transfer sets a shared 7-bit offset pointer and changes no table data. A read transfer returns table bytes in order, starting at the pointer, and moves the pointer one step after each byte. The usual sequence is a write of the offset, then a repeated START, then reads. It works because the read picks up from the pointer that the write just loaded.

The SCL and SDA lines are brought in through flop synchronizers, and all timing runs off the system clock. SDA is open-drain: the block only pulls it low, through an output enable.

Top module: `dispid_i2c_target`

## Requirements
- R1: The target acknowledges only an address byte whose upper 7 bits equal DEV_ADDR (default 0x50); bit 0 is the direction, where 1 means read. With any other address it leaves SDA released until the next START.
- R2: For the first 127 clocks after reset the checksum is still being built. During that time the target never drives SDA and so does not acknowledge even its own address. After that it serves transfers normally.
- R3: Table contents by index: bytes 1 to 6 are 0xFF; bytes 0 and 7 are 0x00; byte 8 is VENDOR_CODE[15:8] (default 0x2C); byte 9 is VENDOR_CODE[7:0] (0x5A); byte 10 is PRODUCT_CODE[7:0] (0x34); byte 11 is PRODUCT_CODE[15:8] (0x12); byte 18 is 0x01; byte 19 is 0x03; every other byte below 127 is 0x00.
- R4: Byte 127 equals 256 minus the 8-bit sum of bytes 0 to 126, so all 128 bytes sum to 0 modulo 256.
- R5: Reset clears the offset pointer, so a read straight after reset starts at byte 0.
- R6: Each data byte of a write is acknowledged and loads the pointer with its low 7 bits, so 0x85 selects byte 5. Writes never change table contents.
- R7: When a write carries several data bytes, each one reloads the pointer, and the last byte decides where the pointer ends up.
- R8: Each byte read returns the entry at the pointer, and the pointer then steps by one, wrapping from 127 to 0. The pointer keeps this value across STOP and START.
- R9: A repeated START followed by a read address continues from the offset loaded by the write before it.
- R10: When the controller answers a read byte with NACK (SDA high in the 9th clock), the target releases SDA and stays off the line until the next START.
- R11: Data goes out MSB first, and an acknowledge pulls SDA low in the 9th clock. The target only starts driving SDA while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND value) |
| sda_oe_o | output | 1 | When 1, the target pulls SDA low |

## Verification
Every cycle, the assertions check the following. The target stays off SDA while the checksum is still being built. It only begins pulling SDA while SCL is low. A wrong address or a controller NACK leaves the line released. The pointer changes only by a write load or a single read step, and a read step is exactly plus one with 7-bit wrap. The checksum stays frozen once it is ready. The bench scenarios are needed to show the table contents byte by byte, the zero sum over a full 128-byte dump, the wrap from 127 to 0, the rule that the last written byte wins, the fact that writes leave the table alone, and how the pointer carries across repeated START and across STOP.

// File: rtl/dispid_pkg.sv
package dispid_pkg;
  localparam int TBL_BYTES = 128;
  localparam int IDX_W     = $clog2(TBL_BYTES);
  localparam logic [IDX_W-1:0] CSUM_IDX = IDX_W'(TBL_BYTES - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_RNEXT
  } link_st_e;

  // Fixed identification content for every index except the checksum slot.
  function automatic logic [7:0] id_byte(input logic [IDX_W-1:0] idx,
                                         input logic [15:0] vendor,
                                         input logic [15:0] product);
    case (idx)
      IDX_W'(1), IDX_W'(2), IDX_W'(3),
      IDX_W'(4), IDX_W'(5), IDX_W'(6): id_byte = 8'hFF;
      IDX_W'(8):  id_byte = vendor[15:8];
      IDX_W'(9):  id_byte = vendor[7:0];
      IDX_W'(10): id_byte = product[7:0];
      IDX_W'(11): id_byte = product[15:8];
      IDX_W'(18): id_byte = 8'h01;
      IDX_W'(19): id_byte = 8'h03;
      default:    id_byte = 8'h00;
    endcase
  endfunction

  // Value that brings a running 8-bit sum to zero.
  function automatic logic [7:0] csum_close(input logic [7:0] partial);
    return 8'h00 - partial;
  endfunction
endpackage

// File: rtl/dispid_sync.sv
module dispid_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_sh[STAGES-1];
  assign sda_s = sda_sh[STAGES-1];
  assign scl_p = scl_sh[STAGES];
  assign sda_p = sda_sh[STAGES];

  assign start_evt = scl_s && scl_p && sda_p && !sda_s;
  assign stop_evt  = scl_s && scl_p && !sda_p && sda_s;
  assign scl_rise  = scl_s && !scl_p;
  assign scl_fall  = !scl_s && scl_p;
endmodule

// File: rtl/dispid_table.sv
module dispid_table
  import dispid_pkg::*;
#(
  parameter logic [15:0] VENDOR_CODE  = 16'h2C5A,
  parameter logic [15:0] PRODUCT_CODE = 16'h1234
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte,
  output logic             ready
);
  logic [IDX_W-1:0] build_idx;
  logic [7:0]       acc, csum;
  logic [7:0]       acc_next;

  assign acc_next = acc + id_byte(build_idx, VENDOR_CODE, PRODUCT_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      build_idx <= '0;
      acc       <= '0;
      csum      <= '0;
      ready     <= 1'b0;
    end else if (!ready) begin
      acc <= acc_next;
      if (build_idx == CSUM_IDX - IDX_W'(1)) begin
        csum  <= csum_close(acc_next);
        ready <= 1'b1;
      end else begin
        build_idx <= build_idx + IDX_W'(1);
      end
    end
  end

  assign rd_byte = (rd_idx == CSUM_IDX) ? csum
                                        : id_byte(rd_idx, VENDOR_CODE, PRODUCT_CODE);

  // R4: once built, the checksum and the ready flag never move again
  assert_csum_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> (ready && $stable(csum)));
endmodule

// File: rtl/dispid_link.sv
module dispid_link
  import dispid_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic [7:0]       tbl_byte,
  output logic [IDX_W-1:0] ptr,
  output logic             sda_oe
);
  link_st_e    st;
  logic [3:0]  bitcnt;
  logic [6:0]  shreg;
  logic        rw, ack_on;
  logic [7:0]  in_byte;
  logic        addr_done, addr_hit, wr_load, rd_load, rd_nack;

  assign in_byte   = {shreg, sda_s};
  assign addr_done = (st == ST_ADDR) && scl_rise && (bitcnt == 4'd7);
  assign addr_hit  = addr_done && ready && (in_byte[7:1] == DEV_ADDR);
  assign wr_load   = (st == ST_WDATA) && scl_rise && (bitcnt == 4'd7);
  assign rd_load   = scl_fall && (((st == ST_AACK) && ack_on && rw) || (st == ST_RNEXT));
  assign rd_nack   = (st == ST_RACK) && scl_rise && sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; shreg <= '0; rw <= 1'b0; ack_on <= 1'b0; sda_oe <= 1'b0;
    end else if (start_evt) begin
      st <= ST_ADDR; bitcnt <= '0; ack_on <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_evt) begin
      st <= ST_IDLE; ack_on <= 1'b0; sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_ADDR: if (scl_rise) begin
          shreg  <= in_byte[6:0];
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd7) begin
            rw <= sda_s;
            st <= addr_hit ? ST_AACK : ST_IDLE;
          end
        end
        ST_AACK: if (scl_fall) begin
          if (!ack_on) begin
            sda_oe <= 1'b1; ack_on <= 1'b1;
          end else begin
            ack_on <= 1'b0; bitcnt <= '0;
            if (rw) begin
              shreg <= tbl_byte[6:0]; sda_oe <= ~tbl_byte[7]; st <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0; st <= ST_WDATA;
            end
          end
        end
        ST_WDATA: if (scl_rise) begin
          shreg  <= in_byte[6:0];
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd7) st <= ST_WACK;
        end
        ST_WACK: if (scl_fall) begin
          if (!ack_on) begin
            sda_oe <= 1'b1; ack_on <= 1'b1;
          end else begin
            sda_oe <= 1'b0; ack_on <= 1'b0; bitcnt <= '0; st <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) bitcnt <= bitcnt + 4'd1;
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0; st <= ST_RACK;
            end else begin
              shreg <= {shreg[5:0], 1'b0}; sda_oe <= ~shreg[6];
            end
          end
        end
        ST_RACK: if (scl_rise) st <= sda_s ? ST_IDLE : ST_RNEXT;
        ST_RNEXT: if (scl_fall) begin
          shreg <= tbl_byte[6:0]; sda_oe <= ~tbl_byte[7]; bitcnt <= '0; st <= ST_RDATA;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (wr_load) ptr <= in_byte[IDX_W-1:0];
    else if (rd_load) ptr <= ptr + IDX_W'(1);
  end

  // R2: silent while the checksum is still being built
  assert_quiet_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !sda_oe);
  // R11: the target only starts pulling SDA while SCL is low
  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  // R1: a wrong address leaves the line released and the link idle
  assert_foreign_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !addr_hit && !start_evt && !stop_evt) |=> (st == ST_IDLE && !sda_oe));
  // R10: a controller NACK ends the read with SDA released
  assert_nack_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_nack && !start_evt && !stop_evt) |=> (st == ST_IDLE && !sda_oe));
  // R8: a read step advances the pointer by exactly one, mod 128
  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> (ptr == $past(ptr) + IDX_W'(1)));
  // R6: the pointer moves only by a write load or a read step
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_load || rd_load) |=> $stable(ptr));
endmodule

// File: rtl/dispid_i2c_target.sv
module dispid_i2c_target
  import dispid_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR     = 7'h50,
  parameter logic [15:0] VENDOR_CODE  = 16'h2C5A,
  parameter logic [15:0] PRODUCT_CODE = 16'h1234,
  parameter int          SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic scl_s, sda_s, start_evt, stop_evt, scl_rise, scl_fall;
  logic ready;
  logic [7:0] tbl_byte;
  logic [IDX_W-1:0] ptr;

  dispid_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  dispid_table #(.VENDOR_CODE(VENDOR_CODE), .PRODUCT_CODE(PRODUCT_CODE)) u_table (
    .clk(clk), .rst_n(rst_n), .rd_idx(ptr), .rd_byte(tbl_byte), .ready(ready)
  );

  dispid_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .ready(ready), .scl_s(scl_s), .sda_s(sda_s),
    .start_evt(start_evt), .stop_evt(stop_evt), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .tbl_byte(tbl_byte), .ptr(ptr), .sda_oe(sda_oe_o)
  );
endmodule

// File: tb/test_dispid_i2c_target.sv
`timescale 1ns/1ps
module test_dispid_i2c_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_drv & ~sda_oe;

  always #2 clk = ~clk;

  dispid_i2c_target i_dispid_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t       exp_q[$];
  logic [7:0] act_q[$];
  int n_chk = 0, n_fail = 0;
  int q = 8;
  logic [7:0] ref_tbl [128];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Reference table built from R3 and R4.
  initial begin
    logic [7:0] s;
    for (int i = 0; i < 128; i++) ref_tbl[i] = 8'h00;
    for (int i = 1; i <= 6; i++) ref_tbl[i] = 8'hFF;
    ref_tbl[8] = 8'h2C; ref_tbl[9] = 8'h5A; ref_tbl[10] = 8'h34; ref_tbl[11] = 8'h12;
    ref_tbl[18] = 8'h01; ref_tbl[19] = 8'h03;
    s = 8'h00;
    for (int i = 0; i < 127; i++) s = s + ref_tbl[i];
    ref_tbl[127] = 8'd0 - s;
  end

  // Scoreboard monitor: compares received bytes against expected ones.
  initial forever begin
    @(posedge clk);
    while (act_q.size() > 0) begin
      logic [7:0] a;
      exp_t e;
      a = act_q.pop_front();
      if (exp_q.size() == 0) check(1'b0, "unexpected byte", a, 0);
      else begin
        e = exp_q.pop_front();
        check(a === e.val, e.tag, a, e.val);
      end
    end
  end

  task automatic qwait(); #(q * 4); endtask

  task automatic i2c_start();
    sda_drv = 1'b1; qwait(); scl_drv = 1'b1; qwait();
    sda_drv = 1'b0; qwait(); scl_drv = 1'b0; qwait();
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; qwait(); scl_drv = 1'b1; qwait(); sda_drv = 1'b1; qwait();
  endtask

  task automatic put_bit(input logic b);
    sda_drv = b; qwait(); scl_drv = 1'b1; qwait(); qwait(); scl_drv = 1'b0; qwait();
  endtask

  task automatic get_bit(output logic b);
    sda_drv = 1'b1; qwait(); scl_drv = 1'b1; qwait(); b = sda_line;
    qwait(); scl_drv = 1'b0; qwait();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack);
  endtask

  task automatic get_byte(input bit last, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      get_bit(b);
      v[i] = b;
    end
    put_bit(last);
    act_q.push_back(v);
  endtask

  task automatic send_addr(input logic rd, input bit expect_ack, input string tag);
    logic ack;
    put_byte({7'h50, rd}, ack);
    check(ack === !expect_ack, tag, ack, !expect_ack);
  endtask

  task automatic send_data(input logic [7:0] v, input string tag);
    logic ack;
    put_byte(v, ack);
    check(ack === 1'b0, tag, ack, 0);
  endtask

  task automatic read_run(input int first, input int n, input string tag, output logic [7:0] sum);
    logic [7:0] v;
    sum = 8'h00;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{ref_tbl[(first + i) % 128], tag});
      get_byte(i == n - 1, v);
      sum = sum + v;
    end
  endtask

  task automatic set_offset(input logic [7:0] off, input string tag);
    i2c_start(); send_addr(1'b0, 1'b1, tag); send_data(off, tag);
  endtask

  task automatic run();
    logic [7:0] sum;
    logic ack, b;
    @(posedge clk); #1;
    check(sda_oe === 1'b0, "R2 reset state", sda_oe, 0);
    rst_n = 1'b1;
    // R2: own address refused while the checksum is still building
    q = 2;
    i2c_start(); send_addr(1'b0, 1'b0, "R2 busy nack"); i2c_stop();
    q = 8;
    repeat (200) @(posedge clk);
    #1;
    // R5 + R3: first read after reset starts at byte 0
    i2c_start(); send_addr(1'b1, 1'b1, "R5 read addr");
    read_run(0, 4, "R5 R3 bytes from reset", sum);
    // R10: after the NACK the target stays off the line
    for (int i = 0; i < 9; i++) begin
      get_bit(b);
      check(b === 1'b1, "R10 released after nack", b, 1);
    end
    i2c_stop();
    // R8: the pointer survives STOP/START (now 4)
    i2c_start(); send_addr(1'b1, 1'b1, "R8 read addr");
    read_run(4, 3, "R8 continue after stop", sum); i2c_stop();
    // R9 + R3: write offset, repeated start, read identity fields
    set_offset(8'h08, "R9 offset write");
    i2c_start(); send_addr(1'b1, 1'b1, "R9 rstart read addr");
    read_run(8, 12, "R9 R3 identity bytes", sum); i2c_stop();
    // R8 + R4: wrap across the checksum byte
    set_offset(8'h7E, "R8 offset write");
    i2c_start(); send_addr(1'b1, 1'b1, "R8 read addr");
    read_run(126, 4, "R8 R4 wrap", sum); i2c_stop();
    // R6: only the low 7 bits are used
    set_offset(8'h85, "R6 offset write");
    i2c_start(); send_addr(1'b1, 1'b1, "R6 read addr");
    read_run(5, 1, "R6 low seven bits", sum); i2c_stop();
    // R7: last of several data bytes wins
    set_offset(8'h10, "R7 first data");
    send_data(8'h12, "R7 second data");
    i2c_start(); send_addr(1'b1, 1'b1, "R7 read addr");
    read_run(18, 2, "R7 last write wins", sum); i2c_stop();
    // R1: other addresses get no acknowledge
    i2c_start(); put_byte({7'h51, 1'b0}, ack);
    check(ack === 1'b1, "R1 addr 0x51 nack", ack, 1); i2c_stop();
    i2c_start(); put_byte({7'h3A, 1'b1}, ack);
    check(ack === 1'b1, "R1 addr 0x3A nack", ack, 1);
    for (int i = 0; i < 8; i++) begin
      get_bit(b);
      check(b === 1'b1, "R1 silent after foreign addr", b, 1);
    end
    i2c_stop();
    // R6: writes of data bytes leave the table intact
    set_offset(8'h00, "R6 write data");
    send_data(8'hAA, "R6 write data");
    send_data(8'h55, "R6 write data");
    send_data(8'h00, "R6 write data");
    i2c_start(); send_addr(1'b1, 1'b1, "R6 dump read addr");
    read_run(0, 128, "R6 R3 full dump", sum); i2c_stop();
    check(sum === 8'h00, "R4 table sums to zero", sum, 0);
    // R11: pointer wrapped back to 0 after the full dump
    i2c_start(); send_addr(1'b1, 1'b1, "R11 read addr");
    read_run(0, 2, "R11 msb first after wrap", sum); i2c_stop();
    repeat (10) @(posedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run();
      begin
        #(200000 * 4);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule